// File: doc/BRIEF.md
# Fixed-Point Vector Multiply-Accumulate Unit

This block is the multiply stage of a SIMD signal-processing datapath. It works on eight lanes of 16 bits each. Every lane owns a 32-bit accumulator that software cannot reach. Each accepted operation takes two 128-bit source vectors. A 4-bit lane-select code can broadcast one lane of the second source to all lanes. A 3-bit function code picks one of three multiply flavours, each in a plain form and an accumulating form:

- signed fractional (Q15) with rounding,
- signed integer with clamping,
- unsigned integer.

The block updates every lane accumulator and returns a 128-bit result vector one clock after the operation is presented. A synchronous clear input zeroes all accumulators. An accumulator can be observed without changing it by issuing an accumulating operation whose first source is zero. The accumulating unsigned form then returns the low half of each accumulator. The accumulating signed form returns the clamped full value.

Top module: `vmac_unit`

## Requirements
- R1: An operation is accepted on a rising edge where `in_valid` is high, `acc_clr` is low and `op_code` is 0 to 5. After that edge, `out_valid` is high for one cycle and `out_vec` carries the result. After every other edge, `out_valid` is low.
- R2: When bit 3 of `lane_sel` is clear (codes 0 to 7), lane i takes lane i of `src_b` as its second operand. When bit 3 is set (codes 8 to F), every lane takes lane `lane_sel[2:0]` of `src_b`. Lane i occupies bits 16i+15 down to 16i of each vector.
- R3: Code 0, fractional multiply. Form p = 2·a·b, signed, modulo 2^32. The lane result is p[31:16] + p[15], modulo 2^16. The accumulator becomes {result, p[15:0] XOR 8000h}.
- R4: Code 1, fractional accumulate. Same as R3, except that p is first increased by the accumulator's upper 16 bits shifted left by 16. The accumulator's lower half does not enter the sum.
- R5: Code 2, high multiply. The accumulator becomes the signed 32-bit product a·b. The lane result is that product clamped to the range 8000h..7FFFh.
- R6: Code 3, high accumulate. The accumulator becomes accumulator + a·b (signed, modulo 2^32). The lane result is the new accumulator clamped to the range 8000h..7FFFh. The stored accumulator is never clamped.
- R7: Code 4, mid-n multiply. The accumulator becomes the unsigned product a·b. The lane result is its low 16 bits.
- R8: Code 5, mid-n accumulate. The accumulator becomes accumulator + a·b (unsigned, modulo 2^32). The lane result is the low 16 bits of the new accumulator.
- R9: When `acc_clr` is high at an edge, every accumulator becomes zero. Any operation presented in that same cycle is dropped, and `out_vec` keeps its value.
- R10: Codes 6 and 7 presented with `in_valid` high are ignored. No accumulator changes, `out_valid` stays low and `out_vec` keeps its value.
- R11: After reset, `out_valid` is low, `out_vec` is zero and every accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op_code | input | 3 | Function code, 0 to 5 defined |
| lane_sel | input | 4 | Second-source lane select / broadcast code |
| src_a | input | 128 | First source vector, eight 16-bit lanes |
| src_b | input | 128 | Second source vector, eight 16-bit lanes |
| acc_clr | input | 1 | Synchronous clear of all accumulators |
| out_valid | output | 1 | Result vector valid |
| out_vec | output | 128 | Result vector, eight 16-bit lanes |

## Verification
An accepted operation's result vector and its `out_valid` pulse both appear after exactly one rising edge. The new accumulator state becomes visible only through the next accumulating operation, which is itself due one edge later. The bench drives every operation on a falling edge. It samples `out_valid` and `out_vec` on the following falling edge, halfway after the one register stage. It then checks that `out_valid` has dropped again one edge later. For dropped or ignored operations it samples at the same point and expects `out_valid` low with `out_vec` unchanged. It follows with a zero-multiplicand accumulate read to show the accumulators held.

// File: rtl/vmac_pkg.sv
package vmac_pkg;

    localparam int OP_W  = 3;
    localparam int SEL_W = 4;

    // function codes
    localparam logic [OP_W-1:0] OP_FMUL = 3'd0;
    localparam logic [OP_W-1:0] OP_FMAC = 3'd1;
    localparam logic [OP_W-1:0] OP_HMUL = 3'd2;
    localparam logic [OP_W-1:0] OP_HMAC = 3'd3;
    localparam logic [OP_W-1:0] OP_NMUL = 3'd4;
    localparam logic [OP_W-1:0] OP_NMAC = 3'd5;

    function automatic logic op_defined(input logic [OP_W-1:0] code);
        return code <= OP_NMAC;
    endfunction

    function automatic logic op_is_frac(input logic [OP_W-1:0] code);
        return (code == OP_FMUL) || (code == OP_FMAC);
    endfunction

    function automatic logic op_is_high(input logic [OP_W-1:0] code);
        return (code == OP_HMUL) || (code == OP_HMAC);
    endfunction

endpackage

// File: rtl/vmac_lane_sel.sv
module vmac_lane_sel
    import vmac_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [SEL_W-1:0]               sel,
    input  logic [LANES-1:0][LANE_W-1:0]   b_in,
    output logic [LANES-1:0][LANE_W-1:0]   b_out
);

    localparam int IDX_W = $clog2(LANES);

    logic             bcast;
    logic [IDX_W-1:0] pick;

    assign bcast = sel[SEL_W-1];
    assign pick  = sel[IDX_W-1:0];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign b_out[i] = bcast ? b_in[pick] : b_in[i];
    end

    // R2: broadcast makes every lane equal the picked source lane
    p_bcast_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bcast |-> (b_out[0] == b_in[pick]) && (b_out[LANES-1] == b_in[pick]));

    // R2: without broadcast the operand passes straight through
    p_pass_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bcast |-> (b_out == b_in));

endmodule

// File: rtl/vmac_lane.sv
module vmac_lane
    import vmac_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [OP_W-1:0]     op,
    input  logic [LANE_W-1:0]   a,
    input  logic [LANE_W-1:0]   b,
    input  logic [2*LANE_W-1:0] acc_q,
    output logic [2*LANE_W-1:0] acc_d,
    output logic [LANE_W-1:0]   res
);

    localparam int ACC_W = 2 * LANE_W;
    localparam logic [LANE_W-1:0] POS_MAX = {1'b0, {(LANE_W-1){1'b1}}};
    localparam logic [LANE_W-1:0] NEG_MIN = {1'b1, {(LANE_W-1){1'b0}}};

    logic [ACC_W-1:0]  a_sx, b_sx, a_zx, b_zx;
    logic [ACC_W-1:0]  prod_s, prod_u, prod_f;
    logic [ACC_W-1:0]  sum;
    logic [LANE_W-1:0] rnd;
    logic              ovf_pos, ovf_neg;

    assign a_sx = {{LANE_W{a[LANE_W-1]}}, a};
    assign b_sx = {{LANE_W{b[LANE_W-1]}}, b};
    assign a_zx = {{LANE_W{1'b0}}, a};
    assign b_zx = {{LANE_W{1'b0}}, b};

    // low ACC_W bits of the product equal the two's-complement product
    assign prod_s = a_sx * b_sx;
    assign prod_u = a_zx * b_zx;
    assign prod_f = {prod_s[ACC_W-2:0], 1'b0};

    always_comb begin
        sum = '0;
        unique case (op)
            OP_FMUL: sum = prod_f;
            OP_FMAC: sum = prod_f + {acc_q[ACC_W-1:LANE_W], {LANE_W{1'b0}}};
            OP_HMUL: sum = prod_s;
            OP_HMAC: sum = acc_q + prod_s;
            OP_NMUL: sum = prod_u;
            OP_NMAC: sum = acc_q + prod_u;
            default: sum = acc_q;
        endcase
    end

    assign rnd     = sum[ACC_W-1:LANE_W] + {{(LANE_W-1){1'b0}}, sum[LANE_W-1]};
    assign ovf_pos = !sum[ACC_W-1] && (sum[ACC_W-2:LANE_W-1] != '0);
    assign ovf_neg = sum[ACC_W-1] && !(&sum[ACC_W-2:LANE_W-1]);

    always_comb begin
        acc_d = acc_q;
        res   = '0;
        if (op_is_frac(op)) begin
            acc_d = {rnd, sum[LANE_W-1:0] ^ NEG_MIN};
            res   = rnd;
        end else if (op_is_high(op)) begin
            acc_d = sum;
            res   = ovf_pos ? POS_MAX : (ovf_neg ? NEG_MIN : sum[LANE_W-1:0]);
        end else if (op_defined(op)) begin
            acc_d = sum;
            res   = sum[LANE_W-1:0];
        end
    end

    // R3: fractional result is mirrored in the upper accumulator half
    p_frac_hi_r3: assert property (@(posedge clk) disable iff (!rst_n)
        op_is_frac(op) |-> (acc_d[ACC_W-1:LANE_W] == res));

    // R5: a positive accumulator beyond the lane range gives the top code
    p_hi_clamp_pos_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_is_high(op) && !acc_d[ACC_W-1] && ($signed(acc_d) > $signed({{LANE_W{1'b0}}, POS_MAX})))
        |-> (res == POS_MAX));

    // R6: a negative accumulator beyond the lane range gives the bottom code
    p_hi_clamp_neg_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_is_high(op) && ($signed(acc_d) < $signed({{LANE_W{1'b1}}, NEG_MIN})))
        |-> (res == NEG_MIN));

    // R10: undefined codes leave the accumulator untouched
    p_undef_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !op_defined(op) |-> (acc_d == acc_q));

endmodule

// File: rtl/vmac_unit.sv
module vmac_unit
    import vmac_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [2:0]              op_code,
    input  logic [3:0]              lane_sel,
    input  logic [LANES*LANE_W-1:0] src_a,
    input  logic [LANES*LANE_W-1:0] src_b,
    input  logic                    acc_clr,
    output logic                    out_valid,
    output logic [LANES*LANE_W-1:0] out_vec
);

    localparam int ACC_W = 2 * LANE_W;

    typedef struct packed {
        logic                           vld;
        logic [LANES-1:0][LANE_W-1:0]   vec;
        logic [LANES-1:0][ACC_W-1:0]    acc;
    } state_t;

    state_t st_d, st_q;

    logic [LANES-1:0][LANE_W-1:0] a_l, b_l, b_pick, res_l;
    logic [LANES-1:0][ACC_W-1:0]  acc_nx;
    logic                         take;

    assign a_l  = src_a;
    assign b_l  = src_b;
    assign take = in_valid && !acc_clr && op_defined(op_code);

    vmac_lane_sel #(
        .LANES  (LANES),
        .LANE_W (LANE_W)
    ) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (lane_sel),
        .b_in  (b_l),
        .b_out (b_pick)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        vmac_lane #(
            .LANE_W (LANE_W)
        ) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .op    (op_code),
            .a     (a_l[i]),
            .b     (b_pick[i]),
            .acc_q (st_q.acc[i]),
            .acc_d (acc_nx[i]),
            .res   (res_l[i])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (acc_clr) begin
            st_d.acc = '0;
        end else if (take) begin
            st_d.vld = 1'b1;
            st_d.vec = res_l;
            st_d.acc = acc_nx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign out_vec   = st_q.vec;

    // R1: an accepted operation is answered after exactly one edge
    p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !acc_clr && (op_code <= 3'd5)) |=> out_valid);

    // R1, R9, R10: anything else leaves the output quiet and unchanged
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && !acc_clr && (op_code <= 3'd5)) |=> (!out_valid && $stable(out_vec)));

    // R9: clear empties every accumulator
    p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_clr |=> (st_q.acc == '0));

endmodule

// File: tb/sim_vmac_unit.sv
`timescale 1ns/1ps
module sim_vmac_unit;

    typedef struct packed {
        logic [15:0]  tag;
        logic [2:0]   op;
        logic [3:0]   sel;
        logic [127:0] a;
        logic [127:0] b;
        logic [127:0] exp;
    } vec_t;

    localparam vec_t TBL [0:8] = '{
        // R7 mid-n multiply, lanes hold i+1 squared
        '{"R7", 3'd4, 4'h0,
          128'h0008_0007_0006_0005_0004_0003_0002_0001,
          128'h0008_0007_0006_0005_0004_0003_0002_0001,
          128'h0040_0031_0024_0019_0010_0009_0004_0001},
        // R8 mid-n accumulate adds 0x10000, low half unchanged
        '{"R8", 3'd5, 4'h0,
          {8{16'h0100}}, {8{16'h0100}},
          128'h0040_0031_0024_0019_0010_0009_0004_0001},
        // R6 high accumulate of zero reads clamped accumulators
        '{"R6", 3'd3, 4'h0, 128'h0, 128'h0, {8{16'h7FFF}}},
        // R6 accumulator itself was not clamped
        '{"R6", 3'd5, 4'h0, 128'h0, 128'h0,
          128'h0040_0031_0024_0019_0010_0009_0004_0001},
        // R5 high multiply with both clamps and an exact 8000h
        '{"R5", 3'd2, 4'h0,
          128'hFF00_0100_8000_0003_FFFF_7FFF_8000_4000,
          128'h0080_00FF_0002_FFFB_0005_7FFF_8000_0002,
          128'h8000_7FFF_8000_FFF1_FFFB_7FFF_7FFF_7FFF},
        // R2 broadcast lane 3 (-1) into a high accumulate
        '{"R2", 3'd3, 4'hB,
          128'h0000_0000_0000_000F_0005_0001_0001_8000,
          128'h0009_0009_0009_0009_FFFF_0009_0009_0009,
          128'h8000_7FFF_8000_FFE2_FFF6_7FFF_7FFF_7FFF},
        // R3 fractional multiply with rounding
        '{"R3", 3'd0, 4'h0,
          128'hFFFE_7FFF_0003_FFFF_0001_0001_8000_4000,
          128'h1000_7FFF_2000_4000_3FFF_4000_8000_4000,
          128'h0000_7FFE_0001_0000_0000_0001_8000_2000},
        // R3 low halves hold product XOR 8000h
        '{"R3", 3'd5, 4'h0, 128'h0, 128'h0,
          128'h4000_8002_4000_0000_FFFE_0000_8000_8000},
        // R4 fractional accumulate uses only the upper half
        '{"R4", 3'd1, 4'h0,
          128'h0000_7FFF_0000_FFFF_0001_0001_4000_0000,
          128'h0000_7FFF_0000_4000_3FFF_4000_4000_0000,
          128'h0000_FFFC_0001_0000_0000_0002_A000_2000}
    };

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [2:0]   op_code = 3'd0;
    logic [3:0]   lane_sel = 4'd0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic         acc_clr = 1'b0;
    logic         out_valid;
    logic [127:0] out_vec;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    vmac_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .lane_sel  (lane_sel),
        .src_a     (src_a),
        .src_b     (src_b),
        .acc_clr   (acc_clr),
        .out_valid (out_valid),
        .out_vec   (out_vec)
    );

    task automatic chk_vec(input string req, input logic [127:0] got, input logic [127:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s out_vec actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic chk_bit(input string req, input logic got, input logic exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s out_valid actual=%b expected=%b", req, got, exp);
        end
    endtask

    // drive on a falling edge, return on the next falling edge
    task automatic issue(input logic [2:0] op, input logic [3:0] sel,
                         input logic [127:0] a, input logic [127:0] b, input logic clr);
        @(negedge clk);
        in_valid = 1'b1;
        op_code  = op;
        lane_sel = sel;
        src_a    = a;
        src_b    = b;
        acc_clr  = clr;
        @(negedge clk);
        in_valid = 1'b0;
        acc_clr  = 1'b0;
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [127:0] held;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk_bit("R11", out_valid, 1'b0);
        chk_vec("R11", out_vec, 128'h0);
        rst_n = 1'b1;
        // R11: accumulators start at zero; R1 valid pulse
        issue(3'd5, 4'h0, 128'h0, 128'h0, 1'b0);
        chk_bit("R1", out_valid, 1'b1);
        chk_vec("R11", out_vec, 128'h0);
        @(negedge clk);
        chk_bit("R1", out_valid, 1'b0);

        for (int k = 0; k < 9; k++) begin
            issue(TBL[k].op, TBL[k].sel, TBL[k].a, TBL[k].b, 1'b0);
            chk_bit("R1", out_valid, 1'b1);
            chk_vec($sformatf("%s", TBL[k].tag), out_vec, TBL[k].exp);
        end

        // R10: undefined codes are ignored
        held = out_vec;
        issue(3'd6, 4'h0, {8{16'h1234}}, {8{16'h0101}}, 1'b0);
        chk_bit("R10", out_valid, 1'b0);
        chk_vec("R10", out_vec, held);
        issue(3'd7, 4'h8, {8{16'h7FFF}}, {8{16'h7FFF}}, 1'b0);
        chk_bit("R10", out_valid, 1'b0);
        chk_vec("R10", out_vec, held);
        issue(3'd5, 4'h0, 128'h0, 128'h0, 1'b0);
        chk_vec("R10", out_vec, 128'h8000_8002_8000_0000_FFFE_0000_8000_8000);

        // R9: clear drops the concurrent operation and empties accumulators
        held = out_vec;
        issue(3'd4, 4'h0, {8{16'h0001}}, {8{16'h0001}}, 1'b1);
        chk_bit("R9", out_valid, 1'b0);
        chk_vec("R9", out_vec, held);
        issue(3'd3, 4'h0, 128'h0, 128'h0, 1'b0);
        chk_vec("R9", out_vec, 128'h0);

        // R2: codes 1..7 do not broadcast, code F broadcasts lane 7
        issue(3'd4, 4'h2, {8{16'h0001}}, 128'h0008_0007_0006_0005_0004_0003_0002_0001, 1'b0);
        chk_vec("R2", out_vec, 128'h0008_0007_0006_0005_0004_0003_0002_0001);
        issue(3'd4, 4'hF, {8{16'h0001}}, 128'h0008_0007_0006_0005_0004_0003_0002_0001, 1'b0);
        chk_vec("R2", out_vec, {8{16'h0008}});

        finish_run();
    end

endmodule